// File: doc/BRIEF.md
# DMA Width-Converting Staging Buffer

This block sits between the read half and the write half of one DMA channel and carries bytes through a single 16-byte staging store. The read half pushes source beats into it and the write half pulls destination beats out of it. Each side has its own beat width of 8, 16, 32 or 128 bits, and the two widths are set independently. On either side a start offset that is not aligned is worked off automatically. The block offers narrower beats on that side until the running offset reaches the configured width's boundary. After that it offers full-width beats.

A transfer begins with `start_i`, which loads both width codes and the low address bits of both start addresses and empties the store. The block then sets the size of every beat through `src_size_o` and `dst_size_o`. Each beat completes with a valid/ready handshake. Beat data is right-justified: the first byte of a beat is in lane 0, bits [7:0]. Raising `flush_i` stops further source intake. The remaining bytes then drain in beats no larger than what is left, and `done_o` reports when the store is empty.

Top module: `dma_stage_buf`

## Requirements
- R1: Width code 2'b00 means 1 byte, 2'b01 means 2 bytes, 2'b10 means 4 bytes and 2'b11 means 16 bytes. Source and destination each have their own code. `src_size_o` and `dst_size_o` report each offered beat using the same encoding.
- R2: Outside flush, the size each side offers is the largest of {1,2,4,16} bytes that does not exceed that side's configured width and that divides the side's current 4-bit offset (offset 0 counts as divisible by 16). After each completed beat, the offset advances by the beat's byte count, modulo 16.
- R3: The store holds 0 to 16 bytes. `src_ready_o` is high exactly when the block is not flushing and the free space is at least the offered source size. `dst_valid_o` is high exactly when the store holds at least one byte and at least the offered destination size. As a result, a 16-byte source beat is taken only into an empty store, and a 16-byte destination beat leaves only from a full one.
- R4: Bytes leave in the order they entered, and the number of bytes delivered equals the number accepted.
- R5: With 8-bit widths, a byte accepted at one clock edge is offered on the destination port in the very next cycle.
- R6: Suppose the aligned source size does not fit the free space and the destination is not offering a beat. In that case the source offers the largest aligned size from R2 that does fit the free space.
- R7: After `flush_i`, `src_ready_o` stays low. Each destination beat is the largest aligned size from R2 that does not exceed the bytes held. `done_o` is high exactly when flushing with an empty store, and it holds until the next start.
- R8: `start_i` empties the store, loads the widths and offsets, and clears flush and done. Handshakes in the start cycle are dropped.
- R9: After reset, both widths are 8-bit, both offsets are 0 and the store is empty. Therefore `src_ready_o`=1, `dst_valid_o`=0, `done_o`=0 and both size outputs are 0.
- R10: Destination data lanes above the offered beat size read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer: load configuration, empty store |
| src_cfg_i | input | 2 | Source width code |
| dst_cfg_i | input | 2 | Destination width code |
| src_ofs_i | input | 4 | Low bits of the source start address |
| dst_ofs_i | input | 4 | Low bits of the destination start address |
| flush_i | input | 1 | Stop intake and drain remaining bytes |
| src_valid_i | input | 1 | Source beat present |
| src_ready_o | output | 1 | Source beat of the offered size is accepted |
| src_size_o | output | 2 | Size code of the source beat wanted |
| src_data_i | input | 128 | Source beat data, right-justified |
| dst_valid_o | output | 1 | Destination beat available |
| dst_ready_i | input | 1 | Destination takes the beat |
| dst_size_o | output | 2 | Size code of the destination beat |
| dst_data_o | output | 128 | Destination beat data, right-justified |
| done_o | output | 1 | Flush complete, store empty |

## Verification
The hardest case to reach from the ports is the source fallback in R6. It occurs only when a wide aligned source beat is blocked by a partly filled store while the destination side is itself waiting for more bytes, for example a 16-byte source that starts at offset 4 feeding a 16-byte destination. The bench reaches it by sweeping every pairing of source and destination width against every source offset, with paired destination offsets and alternating destination back-pressure. On every cycle it predicts the offered sizes and the ready/valid levels from its own byte-count model, so each entry into the fallback is checked as it happens.

// File: rtl/dma_stage_pkg.sv
`timescale 1ns/1ps
package dma_stage_pkg;
  typedef enum logic [1:0] {
    SZ_B1  = 2'b00,
    SZ_B2  = 2'b01,
    SZ_B4  = 2'b10,
    SZ_B16 = 2'b11
  } sz_e;

  function automatic int unsigned sz_bytes(logic [1:0] code);
    case (code)
      SZ_B1:   return 1;
      SZ_B2:   return 2;
      SZ_B4:   return 4;
      default: return 16;
    endcase
  endfunction
endpackage

// File: rtl/dma_beat_sizer.sv
`timescale 1ns/1ps
module dma_beat_sizer
  import dma_stage_pkg::*;
#(
  parameter int unsigned OFS_W = 4,
  parameter int unsigned CNT_W = OFS_W + 1
) (
  input  logic [OFS_W-1:0] ofs_i,
  input  logic [1:0]       cfg_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [1:0]       code_o,
  output logic [CNT_W-1:0] nbytes_o
);
  logic [1:0] tz_code, cap;

  always_comb begin
    // largest supported size the offset is aligned to
    if (ofs_i == '0)              tz_code = SZ_B16;
    else if (ofs_i[1:0] == 2'b00) tz_code = SZ_B4;
    else if (ofs_i[0] == 1'b0)    tz_code = SZ_B2;
    else                          tz_code = SZ_B1;
    cap    = (cfg_i < tz_code) ? cfg_i : tz_code;
    code_o = SZ_B1;
    for (int k = 1; k < 4; k++) begin
      if (2'(k) <= cap && CNT_W'(sz_bytes(2'(k))) <= limit_i) code_o = 2'(k);
    end
    nbytes_o = CNT_W'(sz_bytes(code_o));
  end
endmodule

// File: rtl/dma_byte_ring.sv
`timescale 1ns/1ps
module dma_byte_ring #(
  parameter int unsigned BYTES  = 16,
  parameter int unsigned OFS_W  = $clog2(BYTES),
  parameter int unsigned CNT_W  = OFS_W + 1,
  parameter int unsigned DATA_W = 8 * BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_en_i,
  input  logic [CNT_W-1:0]  wr_nb_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [CNT_W-1:0]  rd_nb_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [7:0]       mem_q [BYTES];
  logic [OFS_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;

  for (genvar s = 0; s < BYTES; s++) begin : g_slot
    logic [OFS_W-1:0] lane;
    assign lane = OFS_W'(s) - wr_ptr_q;
    always_ff @(posedge clk_i) begin
      if (wr_en_i && {1'b0, lane} < wr_nb_i) mem_q[s] <= wr_data_i[8*lane +: 8];
    end
  end

  for (genvar l = 0; l < BYTES; l++) begin : g_lane
    logic [OFS_W-1:0] slot;
    assign slot = rd_ptr_q + OFS_W'(l);
    assign rd_data_o[8*l +: 8] = (CNT_W'(l) < rd_nb_i) ? mem_q[slot] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clear_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_i) wr_ptr_q <= wr_ptr_q + wr_nb_i[OFS_W-1:0];
      if (rd_en_i) rd_ptr_q <= rd_ptr_q + rd_nb_i[OFS_W-1:0];
      count_q <= count_q + (wr_en_i ? wr_nb_i : '0) - (rd_en_i ? rd_nb_i : '0);
    end
  end

  assign count_o = count_q;
endmodule

// File: rtl/dma_stage_buf.sv
`timescale 1ns/1ps
module dma_stage_buf #(
  parameter int unsigned LINE_BYTES = 16,
  localparam int unsigned OFS_W     = $clog2(LINE_BYTES),
  localparam int unsigned CNT_W     = OFS_W + 1,
  localparam int unsigned DATA_W    = 8 * LINE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        src_cfg_i,
  input  logic [1:0]        dst_cfg_i,
  input  logic [OFS_W-1:0]  src_ofs_i,
  input  logic [OFS_W-1:0]  dst_ofs_i,
  input  logic              flush_i,
  input  logic              src_valid_i,
  output logic              src_ready_o,
  output logic [1:0]        src_size_o,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              dst_valid_o,
  input  logic              dst_ready_i,
  output logic [1:0]        dst_size_o,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LINE_BYTES);

  logic [1:0]       src_cfg_q, dst_cfg_q;
  logic [OFS_W-1:0] src_ofs_q, dst_ofs_q;
  logic             flush_q;
  logic [CNT_W-1:0] count, free, src_limit, dst_limit, src_nb, dst_nb;
  logic             dst_ok, wr_en, rd_en;

  assign free      = FULL - count;
  assign dst_limit = flush_q ? count : FULL;

  dma_beat_sizer #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_dst_sz (
    .ofs_i(dst_ofs_q), .cfg_i(dst_cfg_q), .limit_i(dst_limit),
    .code_o(dst_size_o), .nbytes_o(dst_nb)
  );

  assign dst_ok = (count != '0) && (count >= dst_nb);
  // shrink the source beat only when the destination cannot make room
  assign src_limit = (dst_ok || flush_q) ? FULL : free;

  dma_beat_sizer #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_src_sz (
    .ofs_i(src_ofs_q), .cfg_i(src_cfg_q), .limit_i(src_limit),
    .code_o(src_size_o), .nbytes_o(src_nb)
  );

  assign src_ready_o = !flush_q && (free >= src_nb);
  assign dst_valid_o = dst_ok;
  assign wr_en       = src_valid_i && src_ready_o && !start_i;
  assign rd_en       = dst_ok && dst_ready_i && !start_i;
  assign done_o      = flush_q && (count == '0);

  dma_byte_ring #(.BYTES(LINE_BYTES), .OFS_W(OFS_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ring (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(start_i),
    .wr_en_i(wr_en), .wr_nb_i(src_nb), .wr_data_i(src_data_i),
    .rd_en_i(rd_en), .rd_nb_i(dst_nb), .rd_data_o(dst_data_o),
    .count_o(count)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_cfg_q <= '0;
      dst_cfg_q <= '0;
      src_ofs_q <= '0;
      dst_ofs_q <= '0;
      flush_q   <= 1'b0;
    end else if (start_i) begin
      src_cfg_q <= src_cfg_i;
      dst_cfg_q <= dst_cfg_i;
      src_ofs_q <= src_ofs_i;
      dst_ofs_q <= dst_ofs_i;
      flush_q   <= 1'b0;
    end else begin
      if (flush_i) flush_q <= 1'b1;
      if (wr_en) src_ofs_q <= src_ofs_q + src_nb[OFS_W-1:0];
      if (rd_en) dst_ofs_q <= dst_ofs_q + dst_nb[OFS_W-1:0];
    end
  end
endmodule

// File: rtl/dma_stage_buf_chk.sv
`timescale 1ns/1ps
module dma_stage_buf_chk
  import dma_stage_pkg::*;
#(
  parameter int unsigned OFS_W = 4,
  parameter int unsigned CNT_W = OFS_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             src_valid_i,
  input logic             src_ready_o,
  input logic [1:0]       src_size_o,
  input logic             dst_valid_o,
  input logic [1:0]       dst_size_o,
  input logic             done_o,
  input logic [CNT_W-1:0] count_i,
  input logic [OFS_W-1:0] src_ofs_i,
  input logic [OFS_W-1:0] dst_ofs_i,
  input logic             flush_q_i
);
  localparam int unsigned LINE = 1 << OFS_W;
  int unsigned src_b, dst_b;
  logic [OFS_W-1:0] src_mask, dst_mask;

  always_comb begin
    src_b    = sz_bytes(src_size_o);
    dst_b    = sz_bytes(dst_size_o);
    src_mask = OFS_W'(src_b - 1);
    dst_mask = OFS_W'(dst_b - 1);
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_valid_i && src_ready_o && !start_i) |-> (int'(count_i) + int'(src_b) <= int'(LINE)));
  assert_no_underflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o |-> (dst_b <= int'(count_i)));
  assert_line_into_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ready_o && src_size_o == SZ_B16) |-> (count_i == '0));
  assert_src_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> ((src_ofs_i & src_mask) == '0));
  assert_dst_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_valid_o |-> ((dst_ofs_i & dst_mask) == '0));
  assert_flush_blocks_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q_i |-> !src_ready_o);
  assert_done_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!dst_valid_o && count_i == '0));
  assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (count_i == '0 && !done_o));
endmodule

bind dma_stage_buf dma_stage_buf_chk #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .src_size_o(src_size_o),
  .dst_valid_o(dst_valid_o), .dst_size_o(dst_size_o), .done_o(done_o),
  .count_i(count), .src_ofs_i(src_ofs_q), .dst_ofs_i(dst_ofs_q), .flush_q_i(flush_q)
);

// File: tb/tb_dma_stage_buf.sv
`timescale 1ns/1ps
module tb_dma_stage_buf;
  logic         clk = 1'b0, rst_ni = 1'b0;
  logic         start_i = 0, flush_i = 0, src_valid_i = 0, dst_ready_i = 0;
  logic [1:0]   src_cfg_i = 0, dst_cfg_i = 0;
  logic [3:0]   src_ofs_i = 0, dst_ofs_i = 0;
  logic [127:0] src_data_i = '0;
  logic         src_ready_o, dst_valid_o, done_o;
  logic [1:0]   src_size_o, dst_size_o;
  logic [127:0] dst_data_o;
  int errs = 0, chks = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  dma_stage_buf dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .src_cfg_i(src_cfg_i), .dst_cfg_i(dst_cfg_i),
    .src_ofs_i(src_ofs_i), .dst_ofs_i(dst_ofs_i), .flush_i(flush_i),
    .src_valid_i(src_valid_i), .src_ready_o(src_ready_o), .src_size_o(src_size_o),
    .src_data_i(src_data_i), .dst_valid_o(dst_valid_o), .dst_ready_i(dst_ready_i),
    .dst_size_o(dst_size_o), .dst_data_o(dst_data_o), .done_o(done_o)
  );

  task automatic chk(bit ok, string req, longint act, longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbytes(int code);
    return (code == 3) ? 16 : (1 << code);
  endfunction

  function automatic int align_code(int ofs, int cfg);
    int t;
    t = (ofs % 16 == 0) ? 3 : (ofs % 4 == 0) ? 2 : (ofs % 2 == 0) ? 1 : 0;
    return (cfg < t) ? cfg : t;
  endfunction

  function automatic int fit_code(int cap, int lim);
    int c = 0;
    for (int k = 1; k < 4; k++) if (k <= cap && nbytes(k) <= lim) c = k;
    return c;
  endfunction

  function automatic logic [7:0] pat(int seed, int k);
    return 8'((seed * 29 + k * 13 + 7) & 255);
  endfunction

  task automatic do_start(int sc, int dc, int so, int dofs);
    @(negedge clk);
    start_i = 1; src_cfg_i = 2'(sc); dst_cfg_i = 2'(dc);
    src_ofs_i = 4'(so); dst_ofs_i = 4'(dofs);
    src_valid_i = 0; dst_ready_i = 0; flush_i = 0;
    @(negedge clk);
    start_i = 0;
  endtask

  task automatic run_case(int sc, int dc, int so, int dofs, int seed, bit stall);
    int cnt = 0, s_ofs = so, d_ofs = dofs, sent = 0, rcvd = 0, cyc = 0;
    bit fq = 0, freq = 0;
    do_start(sc, dc, so, dofs);
    forever begin
      int free, ac, sexp, dexp, din, dout;
      bit dv_exp, sr_exp, fl_now;
      if (cyc > 0) @(negedge clk);
      cyc++;
      fl_now = (sent >= 40) && !freq;
      flush_i = fl_now;
      src_valid_i = (sent < 40);
      for (int i = 0; i < 16; i++) src_data_i[8*i +: 8] = pat(seed, sent + i);
      dst_ready_i = stall ? ((cyc % 3) != 0) : 1'b1;
      #1;
      free = 16 - cnt;
      dexp = fq ? fit_code(align_code(d_ofs, dc), cnt) : align_code(d_ofs, dc);
      dv_exp = (cnt > 0) && (cnt >= nbytes(dexp));
      ac = align_code(s_ofs, sc);
      sexp = (!fq && !dv_exp && nbytes(ac) > free) ? fit_code(ac, free) : ac;
      sr_exp = !fq && (free >= nbytes(sexp));
      chk(dst_valid_o == dv_exp, "R3 dst_valid", dst_valid_o, dv_exp);
      chk(src_ready_o == sr_exp, "R3 src_ready", src_ready_o, sr_exp);
      chk(done_o == (fq && cnt == 0), "R7 done", done_o, fq && cnt == 0);
      if (fq) chk(!src_ready_o, "R7 intake stopped", src_ready_o, 0);
      if (fq && cnt == 0) begin
        chk(rcvd == sent, "R4 byte total", rcvd, sent);
        flush_i = 0; src_valid_i = 0; dst_ready_i = 0;
        break;
      end
      din = 0; dout = 0;
      if (sr_exp && src_valid_i) begin
        if (sexp != ac) chk(int'(src_size_o) == sexp, "R6 src fallback size", src_size_o, sexp);
        else            chk(int'(src_size_o) == sexp, "R2 src size", src_size_o, sexp);
        if (src_size_o == 2'b11) chk(cnt == 0, "R3 line into empty", cnt, 0);
        din = nbytes(sexp);
      end
      if (dv_exp) begin
        if (fq) chk(int'(dst_size_o) == dexp, "R7 flush size", dst_size_o, dexp);
        else    chk(int'(dst_size_o) == dexp, "R2 dst size", dst_size_o, dexp);
        if (dexp == 3) chk(cnt == 16, "R3 line from full", cnt, 16);
        if (dst_ready_i) begin
          dout = nbytes(dexp);
          for (int i = 0; i < 16; i++) begin
            if (i < dout) chk(dst_data_o[8*i +: 8] == pat(seed, rcvd + i), "R4 byte order",
                              dst_data_o[8*i +: 8], pat(seed, rcvd + i));
            else chk(dst_data_o[8*i +: 8] == 8'h00, "R10 idle lane", dst_data_o[8*i +: 8], 0);
          end
        end
      end
      cnt = cnt + din - dout;
      sent += din; rcvd += dout;
      s_ofs = (s_ofs + din) % 16;
      d_ofs = (d_ofs + dout) % 16;
      if (fl_now) begin fq = 1; freq = 1; end
      if (cyc > 600) begin
        chk(0, "R4 transfer stalled", cyc, 600);
        break;
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errs++; chks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk); #1;
    // R9: reset state
    chk(src_ready_o == 1, "R9 src_ready", src_ready_o, 1);
    chk(dst_valid_o == 0, "R9 dst_valid", dst_valid_o, 0);
    chk(done_o == 0, "R9 done", done_o, 0);
    chk(src_size_o == 0 && dst_size_o == 0, "R9 sizes", {src_size_o, dst_size_o}, 0);

    // R5: one byte through in the next cycle
    do_start(0, 0, 0, 0);
    src_valid_i = 1; src_data_i = 128'h5A_A5; #1;
    chk(dst_valid_o == 0, "R5 empty before", dst_valid_o, 0);
    @(negedge clk);
    src_valid_i = 0; #1;
    chk(dst_valid_o == 1, "R5 next-cycle valid", dst_valid_o, 1);
    chk(dst_data_o == 128'hA5, "R5 data and R10 lanes", dst_data_o[31:0], 32'hA5);

    // R8: start discards held bytes and clears done
    do_start(0, 0, 0, 0); #1;
    chk(dst_valid_o == 0, "R8 start empties", dst_valid_o, 0);
    flush_i = 1; @(negedge clk); flush_i = 0; #1;
    chk(done_o == 1, "R7 done on empty flush", done_o, 1);
    do_start(1, 1, 0, 0); #1;
    chk(done_o == 0, "R8 start clears done", done_o, 0);
    chk(src_ready_o == 1 && src_size_o == 2'b01, "R8 loads width", src_size_o, 1);

    // R1: full-line beat in and out
    do_start(3, 3, 0, 0);
    for (int i = 0; i < 16; i++) src_data_i[8*i +: 8] = 8'(8'h30 + i);
    src_valid_i = 1; #1;
    chk(src_size_o == 2'b11, "R1 src line code", src_size_o, 3);
    @(negedge clk);
    src_valid_i = 0; dst_ready_i = 1; #1;
    chk(src_ready_o == 0, "R3 full blocks intake", src_ready_o, 0);
    chk(dst_valid_o == 1 && dst_size_o == 2'b11, "R1 dst line code", dst_size_o, 3);
    chk(dst_data_o[127:120] == 8'h3F && dst_data_o[7:0] == 8'h30, "R4 line lanes",
        {dst_data_o[127:120], dst_data_o[7:0]}, 16'h3F30);
    @(negedge clk);
    dst_ready_i = 0; #1;
    chk(dst_valid_o == 0, "R3 drained", dst_valid_o, 0);

    // sweep of width pairs and offsets
    for (int sc = 0; sc < 4; sc++)
      for (int dc = 0; dc < 4; dc++)
        for (int so = 0; so < 16; so++)
          run_case(sc, dc, so, (so * 5 + 3 + dc) % 16, sc * 64 + dc * 16 + so, so[0]);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule